// File: doc/BRIEF.md
# Chained Clock-Manager Reset Sequencer

This block brings up a cascade of three clock-management stages that all derive from one reference clock. Each stage after the first takes its input clock from the stage before it. The sequencer runs on the free-running reference clock. It holds every stage in reset until the reference has been reported stable for a set number of consecutive cycles. It then releases the stages in turn, and a stage is released only after the stage feeding it has reported lock.

After bring-up the block keeps watching the lock flags. A stage that fails to lock within the timeout is pulsed in reset again, together with every stage after it. A stage that loses lock sends the chain back to resetting that stage and everything downstream. A sticky counter of timeout retries is kept for diagnosis. It saturates at 15.

Top module: `clkchain_rst_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until the reference has been declared stable, all three `mgr_rst_o` bits are 1, `all_locked_o` is 0 and `retry_cnt_o` is 0. Asserting `rst_n` low takes effect at once, without waiting for a clock edge.
- R2: The reference is declared stable only after `STABLE_CYC` consecutive clock edges that sample `ref_ok` high. Any low sample restarts the count.
- R3: Every reset pulse lasts max(`PULSE_W`, 3) clock cycles, and never fewer than 3. Bit i of `mgr_rst_o` belongs to stage i, and stage 0 is the head of the chain.
- R4: Stage 0 is released first. Stage i (i>0) is released in the cycle after `lock_i[i-1]` is sampled high, and never before.
- R5: If the stage under bring-up has not reported lock `LOCK_TO` edges after its release, that stage and every later stage are pulsed in reset again, and `retry_cnt_o` increments.
- R6: `retry_cnt_o` never decreases except through `rst_n`, and it saturates at 15.
- R7: When any stage that is already released drops its lock flag, the lowest such stage and all stages after it re-enter a reset pulse, and `all_locked_o` falls.
- R8: `all_locked_o` is 1 only when bring-up is complete and all three lock flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| ref_ok | input | 1 | Reference-clock stable indication |
| lock_i | input | 3 | Lock flag of each stage, bit 0 = head of chain |
| mgr_rst_o | output | 3 | Active-high reset of each stage |
| all_locked_o | output | 1 | Whole chain up and locked |
| retry_cnt_o | output | 4 | Sticky saturating count of lock timeouts |

## Verification
The bench breaks the run of stable reference samples partway through. A sequencer that counted total samples instead of consecutive ones would release stage 0 early. It drives all three lock flags high while the middle stage is still being brought up. `all_locked_o` must stay low there, and a design that decoded only the flags would claim lock too soon. It drops an upstream lock during bring-up and again during normal running, to catch a design that restarts from the wrong stage or leaves downstream stages running on a dead clock. It also lets a stage time out over and over, which exposes a retry count that wraps instead of saturating and a timeout that is off by one cycle.

// File: rtl/clkchain_rst_seq.sv
module clkchain_rst_seq #(
  parameter int PULSE_W    = 8,
  parameter int STABLE_CYC = 64,
  parameter int LOCK_TO    = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_ok,
  input  logic [2:0] lock_i,
  output logic [2:0] mgr_rst_o,
  output logic       all_locked_o,
  output logic [3:0] retry_cnt_o
);
  localparam int PW = (PULSE_W < 3) ? 3 : PULSE_W;
  localparam int CW = $clog2(PW + STABLE_CYC + LOCK_TO + 1);

  typedef enum logic [1:0] {S_WAIT, S_PULSE, S_LWAIT, S_RUN} st_t;

  st_t          st;
  logic [1:0]   cur;
  logic [CW-1:0] cnt;
  logic [3:0]   retry;
  logic [2:0]   watch, drop;
  logic [1:0]   first;

  assign watch = (st == S_RUN) ? 3'b111 :
                 (st == S_PULSE || st == S_LWAIT) ? ((3'b001 << cur) - 3'b001) : 3'b000;
  assign drop  = ~lock_i & watch;
  assign first = drop[0] ? 2'd0 : (drop[1] ? 2'd1 : 2'd2);

  for (genvar i = 0; i < 3; i++) begin : g_rst
    assign mgr_rst_o[i] = (st == S_WAIT) || (2'(i) > cur) ||
                          ((2'(i) == cur) && (st == S_PULSE));
  end

  assign all_locked_o = (st == S_RUN) && (&lock_i);
  assign retry_cnt_o  = retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_WAIT;
      cur   <= 2'd0;
      cnt   <= '0;
      retry <= 4'd0;
    end else begin
      case (st)
        S_WAIT:
          if (!ref_ok) cnt <= '0;
          else if (cnt == CW'(STABLE_CYC - 1)) begin
            st  <= S_PULSE;
            cur <= 2'd0;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_PULSE:
          if (|drop) begin
            cur <= first;
            cnt <= '0;
          end else if (cnt == CW'(PW - 1)) begin
            st  <= S_LWAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_LWAIT:
          if (|drop) begin
            st  <= S_PULSE;
            cur <= first;
            cnt <= '0;
          end else if (lock_i[cur]) begin
            cnt <= '0;
            if (cur == 2'd2) st <= S_RUN;
            else cur <= cur + 2'd1;
          end else if (cnt == CW'(LOCK_TO - 1)) begin
            st  <= S_PULSE;
            cnt <= '0;
            if (retry != 4'd15) retry <= retry + 4'd1;
          end else cnt <= cnt + 1'b1;
        S_RUN:
          if (|drop) begin
            st  <= S_PULSE;
            cur <= first;
            cnt <= '0;
          end
        default: st <= S_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/clkchain_rst_seq_chk.sv
module clkchain_rst_seq_chk #(
  parameter int PULSE_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_ok,
  input logic [2:0] lock_i,
  input logic [2:0] mgr_rst_o,
  input logic       all_locked_o,
  input logic [3:0] retry_cnt_o
);
  localparam int PW = (PULSE_W < 3) ? 3 : PULSE_W;

  logic [7:0] run_q [3];

  for (genvar i = 0; i < 3; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q[i] <= 8'd0;
      else if (!mgr_rst_o[i]) run_q[i] <= 8'd0;
      else if (run_q[i] != 8'hFF) run_q[i] <= run_q[i] + 8'd1;
    end

    p_pulse_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mgr_rst_o[i]) |-> (run_q[i] >= 8'(PW)));

    if (i > 0) begin : g_ord
      p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mgr_rst_o[i]) |-> $past(lock_i[i-1]));
    end
  end

  p_locked_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    all_locked_o |-> (&lock_i));

  p_retry_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt_o >= $past(retry_cnt_o));

  p_retry_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt_o == 4'd15) |=> (retry_cnt_o == 4'd15));

  p_head_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_rst_o == 3'b000 && !lock_i[0]) |=> (mgr_rst_o == 3'b111));

  p_no_lock_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ok && mgr_rst_o == 3'b111 && retry_cnt_o == 4'd0 && $past(mgr_rst_o) == 3'b111)
      |-> !all_locked_o);
endmodule

bind clkchain_rst_seq clkchain_rst_seq_chk #(.PULSE_W(PULSE_W)) u_chk (.*);

// File: tb/test_clkchain_rst_seq.sv
module test_clkchain_rst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_ok = 1'b0;
  logic [2:0] lock_i = 3'b000;
  logic [2:0] mgr_rst_o;
  logic       all_locked_o;
  logic [3:0] retry_cnt_o;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  clkchain_rst_seq #(.PULSE_W(5), .STABLE_CYC(4), .LOCK_TO(20)) i_clkchain_rst_seq (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_i(lock_i),
    .mgr_rst_o(mgr_rst_o), .all_locked_o(all_locked_o), .retry_cnt_o(retry_cnt_o));

  // {req, steps, ref_ok, lock, exp rst, exp all_locked, exp retry}
  localparam int NV = 24;
  localparam logic [20:0] VEC [NV] = '{
    {4'd2, 5'd2,  1'b1, 3'b000, 3'b111, 1'b0, 4'd0},  // R2 counting
    {4'd2, 5'd1,  1'b0, 3'b000, 3'b111, 1'b0, 4'd0},  // R2 break restarts count
    {4'd2, 5'd3,  1'b1, 3'b000, 3'b111, 1'b0, 4'd0},  // R2
    {4'd2, 5'd1,  1'b1, 3'b000, 3'b111, 1'b0, 4'd0},  // R2 declared stable
    {4'd3, 5'd4,  1'b1, 3'b000, 3'b111, 1'b0, 4'd0},  // R3 pulse held
    {4'd3, 5'd1,  1'b1, 3'b000, 3'b110, 1'b0, 4'd0},  // R3 stage 0 freed
    {4'd4, 5'd2,  1'b1, 3'b000, 3'b110, 1'b0, 4'd0},  // R4 stage 1 held
    {4'd4, 5'd1,  1'b1, 3'b001, 3'b100, 1'b0, 4'd0},  // R4 stage 1 freed
    {4'd8, 5'd1,  1'b1, 3'b111, 3'b000, 1'b0, 4'd0},  // R8 flags high early
    {4'd8, 5'd3,  1'b1, 3'b111, 3'b000, 1'b1, 4'd0},  // R8 running
    {4'd7, 5'd1,  1'b1, 3'b101, 3'b110, 1'b0, 4'd0},  // R7 stage 1 drops
    {4'd3, 5'd4,  1'b1, 3'b001, 3'b110, 1'b0, 4'd0},  // R3
    {4'd3, 5'd1,  1'b1, 3'b001, 3'b100, 1'b0, 4'd0},  // R3
    {4'd5, 5'd19, 1'b1, 3'b001, 3'b100, 1'b0, 4'd0},  // R5 within window
    {4'd5, 5'd1,  1'b1, 3'b001, 3'b110, 1'b0, 4'd1},  // R5 timeout
    {4'd5, 5'd4,  1'b1, 3'b001, 3'b110, 1'b0, 4'd1},  // R5
    {4'd5, 5'd1,  1'b1, 3'b001, 3'b100, 1'b0, 4'd1},  // R5
    {4'd4, 5'd1,  1'b1, 3'b011, 3'b000, 1'b0, 4'd1},  // R4 stage 2 freed
    {4'd7, 5'd1,  1'b1, 3'b001, 3'b110, 1'b0, 4'd1},  // R7 upstream drop
    {4'd7, 5'd4,  1'b1, 3'b001, 3'b110, 1'b0, 4'd1},  // R7
    {4'd7, 5'd1,  1'b1, 3'b001, 3'b100, 1'b0, 4'd1},  // R7
    {4'd4, 5'd1,  1'b1, 3'b011, 3'b000, 1'b0, 4'd1},  // R4
    {4'd8, 5'd2,  1'b1, 3'b111, 3'b000, 1'b1, 4'd1},  // R8
    {4'd7, 5'd1,  1'b1, 3'b110, 3'b111, 1'b0, 4'd1}   // R7 head drops
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {mgr_rst_o, all_locked_o, retry_cnt_o}, {3'b111, 1'b0, 4'd0});
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < int'(VEC[v][16:12]); s++) begin
        ref_ok = VEC[v][11];
        lock_i = VEC[v][10:8];
        @(posedge clk); #1;
        check($sformatf("R%0d row %0d", VEC[v][20:17], v),
              {mgr_rst_o, all_locked_o, retry_cnt_o}, {VEC[v][7:0]});
      end
    end
    // R6: stage 0 never locks; retries pile up and saturate
    lock_i = 3'b000;
    repeat (25 * 20) @(posedge clk);
    #1;
    check("R6", {4'd0, retry_cnt_o}, {4'd0, 4'd15});
    repeat (60) @(posedge clk);
    #1;
    check("R6 sticky", {4'd0, retry_cnt_o}, {4'd0, 4'd15});
    check("R5 downstream held", {5'd0, mgr_rst_o[2:1]}, {5'd0, 2'b11});
    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R1 async", {mgr_rst_o, all_locked_o, retry_cnt_o}, {3'b111, 1'b0, 4'd0});
    @(negedge clk);
    rst_n = 1'b1;
    ref_ok = 1'b0;
    lock_i = 3'b111;
    repeat (10) @(posedge clk);
    #1;
    check("R1 no stable ref", {mgr_rst_o, all_locked_o, retry_cnt_o}, {3'b111, 1'b0, 4'd0});
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule